// File: doc/BRIEF.md
# Two-Wire Configuration Port with Serial-Select Fallback

This block is the slave front end that software uses to load a bank of configuration registers. It listens on a two-wire bus made of a clock and an open-drain data line. It checks the 7-bit device address, takes a pointer byte, and then writes data bytes to a register-file port or returns register contents on reads. The top bit of the pointer byte turns on stepping. Stepping stays inside one of two register sections and never carries from the first section into the second.

The address-select pin has two roles. Before the port is enabled, it supplies the low bit of the device address. A register write that sets the enable bit turns the port on for good, and the block emits a one-cycle request to load register defaults. After that, any falling edge on the select pin switches the port for good to a chip-select framed serial mode. In that mode bytes are taken on clock rising edges and the data line is never driven.

All pins pass through two-flop synchronizers into the system clock domain. Start and stop conditions are data-line edges while the bus clock is high, and either one resets the byte sequencing.

Top module: `serial_cfg_port`

## Requirements
- R1: A bus address byte acknowledges (data line pulled low in the ninth clock) only when bits 7:2 equal 001100 and bit 1 equals the synchronized select pin. Bit 0 is read/write, with 1 meaning read. Any other address gets no acknowledge.
- R2: In a write, the byte after the address loads the pointer from its low seven bits and the stepping flag from bit 7. Every later byte is acknowledged and produces one write of that byte to the register at the pointer.
- R3: With the stepping flag clear, every data byte of a transfer targets the same register.
- R4: With the stepping flag set and the pointer in section 01h..08h, the pointer advances by one after each data byte, and 08h wraps to 01h.
- R5: With the stepping flag set and the pointer in section 09h..11h, the pointer advances by one after each data byte, and 11h wraps to 09h. The pointer never moves from 08h to 09h.
- R6: A read address byte is followed at once by the register at the pointer, most significant bit first. A master acknowledge fetches the next byte, stepping first if the flag is set. A master no-acknowledge ends the read.
- R7: A data byte to a pointer outside 01h..11h is acknowledged but writes nothing. A read at such a pointer returns 00h.
- R8: A start condition anywhere, including in the middle of a byte, restarts address reception. A stop condition returns the port to idle with the data line released.
- R9: Writing a byte with bit 0 set to register 08h sets the enable output, which then stays set until reset. The defaults-load output pulses for one cycle only on that first enabling write.
- R10: A falling edge on the select pin sets serial-select mode permanently, but only while the enable output is set.
- R11: In serial-select mode, a frame is the select pin held low. Its bytes are sampled on clock rising edges: address 30h, then pointer, then data, with the same pointer rules as R2 to R5. Any other address byte is ignored, and the data line is never driven.
- R12: Each register write is a single-cycle pulse on the write strobe, with address and data valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock (serial clock in select mode) |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sel_i | input | 1 | Address low bit / serial chip select |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | PTR_W | Register address (current pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o, combinational |
| cp_en_o | output | 1 | Control port enabled (sticky) |
| load_defaults_o | output | 1 | One-cycle request to load register defaults |
| spi_mode_o | output | 1 | Serial-select mode latched |

## Verification
A pin change becomes visible to the sequencer three clock edges later: two synchronizer flops plus the edge-detect register. The acknowledge or data-bit drive appears on sda_oe_o at the following edge. A write strobe follows one edge after the byte-closing bus-clock edge is seen, and the pointer step lands one edge after the strobe. The bench holds each bus-clock phase for twelve system clocks and samples the data line and outputs on the falling system-clock edge in the middle of a phase, well after every one of those delays. Register effects are judged from a register-file model after each transfer ends.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = 4;
  localparam logic [BIT_CW-1:0] ACK_SLOT = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MAP,
    ST_WR,
    ST_RD,
    ST_SKIP
  } cfgp_state_e;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign q_o    = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/cfgp_map_ptr.sv
module cfgp_map_ptr #(
  parameter int PTR_W = 7,
  parameter int B0_LO = 1,
  parameter int B0_HI = 8,
  parameter int B1_LO = 9,
  parameter int B1_HI = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [PTR_W:0]   ld_val_i,   // {incr, pointer}
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             incr_o,
  output logic             in_range_o
);
  localparam logic [PTR_W-1:0] LO0 = PTR_W'(B0_LO);
  localparam logic [PTR_W-1:0] HI0 = PTR_W'(B0_HI);
  localparam logic [PTR_W-1:0] LO1 = PTR_W'(B1_LO);
  localparam logic [PTR_W-1:0] HI1 = PTR_W'(B1_HI);

  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic             incr_q, in0, in1;

  assign in0 = (ptr_q >= LO0) && (ptr_q <= HI0);
  assign in1 = (ptr_q >= LO1) && (ptr_q <= HI1);

  // each section wraps onto itself
  always_comb begin
    ptr_nxt = ptr_q;
    if (in0)      ptr_nxt = (ptr_q == HI0) ? LO0 : ptr_q + 1'b1;
    else if (in1) ptr_nxt = (ptr_q == HI1) ? LO1 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      incr_q <= 1'b0;
    end else if (ld_i) begin
      ptr_q  <= ld_val_i[PTR_W-1:0];
      incr_q <= ld_val_i[PTR_W];
    end else if (step_i && incr_q) begin
      ptr_q  <= ptr_nxt;
    end
  end

  assign ptr_o      = ptr_q;
  assign incr_o     = incr_q;
  assign in_range_o = in0 | in1;
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfgp_pkg::*;
#(
  parameter int          PTR_W     = 7,
  parameter int          B0_LO     = 1,
  parameter int          B0_HI     = 8,
  parameter int          B1_LO     = 9,
  parameter int          B1_HI     = 17,
  parameter int          CPEN_ADDR = 8,
  parameter int          CPEN_BIT  = 0,
  parameter logic [5:0]  DEV_HI    = 6'b001100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             sel_i,
  output logic             reg_we_o,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic [7:0]       reg_wdata_o,
  input  logic [7:0]       reg_rdata_i,
  output logic             cp_en_o,
  output logic             load_defaults_o,
  output logic             spi_mode_o
);
  localparam logic [PTR_W-1:0] CPEN_A   = PTR_W'(CPEN_ADDR);
  localparam logic [6:0]       SPI_ADDR = {DEV_HI, 1'b0};

  logic [2:0] pin_q, pin_rise, pin_fall;
  logic scl_s, sda_s, sel_s, scl_rise, scl_fall, start_c, stop_c, cs_fall, cs_rise;

  cfgp_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sel_i, sda_i, scl_i}),
    .q_o   (pin_q),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  cfgp_state_e          st_q;
  logic [BIT_CW-1:0]    bit_cnt_q;
  logic [BYTE_W-1:0]    sh_q, tx_q, wdata_q, byte_now, rd_load;
  logic                 in_ack_q, rd_ack_q, rd_data_q, we_q, step_q, oe_q;
  logic                 spi_q, cpen_q, ldef_q;
  logic                 byte_evt, id_ok, map_ld, rd_step, ptr_step, map_incr, map_ok;
  logic [PTR_W-1:0]     ptr;

  assign scl_s    = pin_q[0];
  assign sda_s    = pin_q[1];
  assign sel_s    = pin_q[2];
  assign scl_rise = pin_rise[0];
  assign scl_fall = pin_fall[0];
  assign cs_fall  = pin_fall[2];
  assign cs_rise  = pin_rise[2];
  // clock high and not just risen: held high over the data edge
  assign start_c  = ~spi_q & scl_s & ~scl_rise & pin_fall[1];
  assign stop_c   = ~spi_q & scl_s & ~scl_rise & pin_rise[1];

  assign byte_now = spi_q ? {sh_q[6:0], sda_s} : sh_q;
  assign byte_evt = (st_q inside {ST_ADDR, ST_MAP, ST_WR}) &&
                    (spi_q ? (scl_rise && bit_cnt_q == 4'd7)
                           : (scl_fall && bit_cnt_q == ACK_SLOT && !in_ack_q));
  assign id_ok    = spi_q ? (byte_now[7:1] == SPI_ADDR && !byte_now[0])
                          : (byte_now[7:2] == DEV_HI && byte_now[1] == sel_s);
  assign map_ld   = byte_evt && (st_q == ST_MAP);
  assign rd_step  = ~spi_q && (st_q == ST_RD) && scl_rise && bit_cnt_q == ACK_SLOT &&
                    !in_ack_q && rd_data_q && !sda_s;
  assign ptr_step = step_q | rd_step;
  assign rd_load  = map_ok ? reg_rdata_i : '0;

  cfgp_map_ptr #(
    .PTR_W(PTR_W), .B0_LO(B0_LO), .B0_HI(B0_HI), .B1_LO(B1_LO), .B1_HI(B1_HI)
  ) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (map_ld),
    .ld_val_i  ({byte_now[7], byte_now[PTR_W-1:0]}),
    .step_i    (ptr_step),
    .ptr_o     (ptr),
    .incr_o    (map_incr),
    .in_range_o(map_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      wdata_q   <= '0;
      in_ack_q  <= 1'b0;
      rd_ack_q  <= 1'b0;
      rd_data_q <= 1'b0;
      we_q      <= 1'b0;
      step_q    <= 1'b0;
      oe_q      <= 1'b0;
      spi_q     <= 1'b0;
      cpen_q    <= 1'b0;
      ldef_q    <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      step_q <= 1'b0;
      ldef_q <= 1'b0;
      if (cpen_q && cs_fall && !spi_q) begin
        spi_q     <= 1'b1;
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        oe_q      <= 1'b0;
      end else if (spi_q && cs_fall) begin
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
      end else if (spi_q && cs_rise) begin
        st_q      <= ST_IDLE;
      end else if (start_c) begin
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        oe_q      <= 1'b0;
      end else if (stop_c) begin
        st_q      <= ST_IDLE;
        in_ack_q  <= 1'b0;
        oe_q      <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt_q < ACK_SLOT) begin
            sh_q      <= {sh_q[6:0], sda_s};
            bit_cnt_q <= (spi_q && bit_cnt_q == 4'd7) ? '0 : bit_cnt_q + 4'd1;
          end else begin
            in_ack_q <= 1'b1;
            rd_ack_q <= ~sda_s;
          end
        end
        if (byte_evt) begin
          unique case (st_q)
            ST_ADDR: begin
              if (id_ok) begin
                st_q      <= byte_now[0] ? ST_RD : ST_MAP;
                rd_data_q <= 1'b0;
                oe_q      <= ~spi_q;
              end else begin
                st_q      <= ST_SKIP;
              end
            end
            ST_MAP: begin
              st_q <= ST_WR;
              oe_q <= ~spi_q;
            end
            default: begin
              we_q    <= map_ok;
              wdata_q <= byte_now;
              step_q  <= 1'b1;
              oe_q    <= ~spi_q;
              if (ptr == CPEN_A && byte_now[CPEN_BIT]) begin
                cpen_q <= 1'b1;
                ldef_q <= ~cpen_q;
              end
            end
          endcase
        end
        if (!spi_q && scl_fall) begin
          if (in_ack_q) begin
            in_ack_q  <= 1'b0;
            bit_cnt_q <= '0;
            if (st_q == ST_RD) begin
              if (rd_ack_q) begin
                tx_q      <= rd_load;
                oe_q      <= ~rd_load[7];
                rd_data_q <= 1'b1;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_SKIP;
              end
            end else begin
              oe_q <= 1'b0;
            end
          end else if (st_q == ST_RD) begin
            if (bit_cnt_q == ACK_SLOT) oe_q <= 1'b0;
            else if (bit_cnt_q != '0)  oe_q <= ~tx_q[~bit_cnt_q[2:0]];
          end
        end
      end
    end
  end

  assign sda_oe_o        = oe_q;
  assign reg_we_o        = we_q;
  assign reg_addr_o      = ptr;
  assign reg_wdata_o     = wdata_q;
  assign cp_en_o         = cpen_q;
  assign load_defaults_o = ldef_q;
  assign spi_mode_o      = spi_q;
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
  parameter int PTR_W = 7,
  parameter int B0_LO = 1,
  parameter int B0_HI = 8,
  parameter int B1_LO = 9,
  parameter int B1_HI = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_o,
  input logic [PTR_W-1:0] reg_addr_o,
  input logic             sda_oe_o,
  input logic             cp_en_o,
  input logic             load_defaults_o,
  input logic             spi_mode_o,
  input logic             ptr_step_i,
  input logic             map_incr_i
);
  localparam logic [PTR_W-1:0] LO0 = PTR_W'(B0_LO);
  localparam logic [PTR_W-1:0] HI0 = PTR_W'(B0_HI);
  localparam logic [PTR_W-1:0] LO1 = PTR_W'(B1_LO);
  localparam logic [PTR_W-1:0] HI1 = PTR_W'(B1_HI);

  p_we_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ((reg_addr_o >= LO0 && reg_addr_o <= HI0) ||
                  (reg_addr_o >= LO1 && reg_addr_o <= HI1)));

  p_we_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_hold_ptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_step_i && !map_incr_i) |=> $stable(reg_addr_o));

  p_wrap_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_step_i && map_incr_i && reg_addr_o == HI0) |=> (reg_addr_o == LO0));

  p_wrap_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_step_i && map_incr_i && reg_addr_o == HI1) |=> (reg_addr_o == LO1));

  p_en_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_en_o |=> cp_en_o);

  p_defaults_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_defaults_o |-> $rose(cp_en_o));

  p_sel_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_mode_o |=> spi_mode_o);

  p_sel_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_mode_o) |-> cp_en_o);

  p_sel_no_drive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_mode_o |-> !sda_oe_o);
endmodule

bind serial_cfg_port cfgp_chk #(
  .PTR_W(PTR_W), .B0_LO(B0_LO), .B0_HI(B0_HI), .B1_LO(B1_LO), .B1_HI(B1_HI)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_we_o       (reg_we_o),
  .reg_addr_o     (reg_addr_o),
  .sda_oe_o       (sda_oe_o),
  .cp_en_o        (cp_en_o),
  .load_defaults_o(load_defaults_o),
  .spi_mode_o     (spi_mode_o),
  .ptr_step_i     (ptr_step),
  .map_incr_i     (map_incr)
);

// File: tb/serial_cfg_port_tb.sv
`timescale 1ns/1ps
module serial_cfg_port_tb_top;
  localparam int Q = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sel = 1'b0;
  logic       sda_oe, we, cp_en, ldef, spi_mode;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic       sda_bus;
  logic [7:0] regs [128];

  int checks = 0, errors = 0, wr_cnt = 0, ldef_cnt = 0, oe_spi_cnt = 0;

  always #4 clk = ~clk;

  assign sda_bus = sda_oe ? 1'b0 : m_sda;
  assign rdata   = regs[addr];

  serial_cfg_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .sel_i(sel), .reg_we_o(we), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata), .cp_en_o(cp_en), .load_defaults_o(ldef), .spi_mode_o(spi_mode)
  );

  // register file model: initial value of entry i is i ^ A5
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) regs[i] <= 8'(i) ^ 8'hA5;
    end else begin
      if (we) begin
        regs[addr] <= wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (ldef) ldef_cnt <= ldef_cnt + 1;
      if (spi_mode && sda_oe) oe_spi_cnt <= oe_spi_cnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; w(Q); scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; w(Q); scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
  endtask

  task automatic i2c_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; w(Q); scl = 1'b1; w(Q); scl = 1'b0;
    end
    w(Q);
  endtask

  task automatic i2c_tx(input logic [7:0] b, output logic ack);
    i2c_bits(b, 8);
    m_sda = 1'b1; w(Q); scl = 1'b1; w(Q);
    ack = ~sda_bus;
    scl = 1'b0; w(Q);
  endtask

  task automatic i2c_rx(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(Q); scl = 1'b1; w(Q); b = {b[6:0], sda_bus}; scl = 1'b0;
    end
    m_sda = ~mack; w(Q); scl = 1'b1; w(Q); scl = 1'b0; w(Q); m_sda = 1'b1;
  endtask

  task automatic i2c_write(input logic [7:0] map, input logic [7:0] d0, input int n,
                           input logic [7:0] step, output logic ack_last);
    logic a;
    i2c_start();
    i2c_tx(8'h30, a);
    i2c_tx(map, a);
    ack_last = a;
    for (int i = 0; i < n; i++) begin
      i2c_tx(d0 + 8'(i) * step, a);
      ack_last = a;
    end
    i2c_stop();
  endtask

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q); scl = 1'b1; w(Q); scl = 1'b0;
    end
  endtask

  task automatic spi_frame(input logic [7:0] a, input logic [7:0] map,
                           input logic [7:0] d0, input logic [7:0] d1, input int n);
    scl = 1'b0; sel = 1'b1; w(Q); sel = 1'b0; w(Q);
    spi_byte(a); spi_byte(map);
    if (n > 0) spi_byte(d0);
    if (n > 1) spi_byte(d1);
    w(Q); sel = 1'b1; m_sda = 1'b1; w(Q);
  endtask

  task automatic t_reset();
    chk("R8 reset sda_oe", int'(sda_oe), 0);
    chk("R12 reset we", int'(we), 0);
    chk("R9 reset cp_en", int'(cp_en), 0);
    chk("R10 reset spi", int'(spi_mode), 0);
  endtask

  task automatic t_sel_before_enable();
    sel = 1'b1; w(Q); sel = 1'b0; w(Q);
    chk("R10 no latch before enable", int'(spi_mode), 0);
  endtask

  task automatic t_address();
    logic a;
    i2c_start(); i2c_tx(8'h30, a); i2c_stop();
    chk("R1 match ack", int'(a), 1);
    i2c_start(); i2c_tx(8'h32, a); i2c_stop();
    chk("R1 low-bit mismatch nack", int'(a), 0);
    i2c_start(); i2c_tx(8'h70, a); i2c_stop();
    chk("R1 upper mismatch nack", int'(a), 0);
    sel = 1'b1; w(Q);
    i2c_start(); i2c_tx(8'h32, a); i2c_stop();
    chk("R1 select pin high ack", int'(a), 1);
    sel = 1'b0; w(Q);
  endtask

  task automatic t_write();
    logic a;
    int c0 = wr_cnt;
    i2c_write(8'h03, 8'h5A, 1, 8'h00, a);
    chk("R2 ack", int'(a), 1);
    chk("R2 data", int'(regs[3]), 'h5A);
    chk("R12 one write", wr_cnt - c0, 1);
  endtask

  task automatic t_fixed();
    logic a;
    int c0 = wr_cnt;
    i2c_write(8'h05, 8'hA1, 3, 8'h01, a);
    chk("R3 last value", int'(regs[5]), 'hA3);
    chk("R3 neighbour", int'(regs[6]), 'h06 ^ 'hA5);
    chk("R3 three writes", wr_cnt - c0, 3);
  endtask

  task automatic t_bank_lo();
    logic a;
    i2c_write(8'h87, 8'h11, 3, 8'h11, a);
    chk("R4 at 07", int'(regs[7]), 'h11);
    chk("R4 at 08", int'(regs[8]), 'h22);
    chk("R4 wrap to 01", int'(regs[1]), 'h33);
    chk("R5 no carry into 09", int'(regs[9]), 'h09 ^ 'hA5);
  endtask

  task automatic t_bank_hi();
    logic a;
    i2c_write(8'h90, 8'h44, 3, 8'h11, a);
    chk("R5 at 10", int'(regs[16]), 'h44);
    chk("R5 at 11", int'(regs[17]), 'h55);
    chk("R5 wrap to 09", int'(regs[9]), 'h66);
  endtask

  task automatic t_out_of_range();
    logic a;
    logic [7:0] b;
    int c0 = wr_cnt;
    i2c_write(8'h15, 8'h77, 1, 8'h00, a);
    chk("R7 oor ack", int'(a), 1);
    chk("R7 oor no write", wr_cnt - c0, 0);
    i2c_write(8'h00, 8'h00, 0, 8'h00, a);
    i2c_start(); i2c_tx(8'h31, a); i2c_rx(1'b0, b); i2c_stop();
    chk("R7 oor read zero", int'(b), 0);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b0, b1, b2;
    i2c_write(8'h87, 8'h00, 0, 8'h00, a);
    i2c_start(); i2c_tx(8'h31, a);
    chk("R6 read addr ack", int'(a), 1);
    i2c_rx(1'b1, b0); i2c_rx(1'b1, b1); i2c_rx(1'b0, b2); i2c_stop();
    chk("R6 first", int'(b0), 'h11);
    chk("R6 stepped", int'(b1), 'h22);
    chk("R6 wrapped R4", int'(b2), 'h33);
    chk("R6 released", int'(sda_oe), 0);
    i2c_write(8'h03, 8'h00, 0, 8'h00, a);
    i2c_start(); i2c_tx(8'h31, a); i2c_rx(1'b1, b0); i2c_rx(1'b0, b1); i2c_stop();
    chk("R6 fixed first", int'(b0), 'h5A);
    chk("R6 fixed second R3", int'(b1), 'h5A);
  endtask

  task automatic t_restart();
    logic a;
    int c0 = wr_cnt;
    i2c_start(); i2c_tx(8'h30, a); i2c_tx(8'h04, a);
    i2c_bits(8'hFF, 4);
    i2c_start(); i2c_tx(8'h30, a); i2c_tx(8'h06, a); i2c_tx(8'h99, a);
    i2c_stop();
    chk("R8 aborted byte dropped", int'(regs[4]), 'h04 ^ 'hA5);
    chk("R8 after restart", int'(regs[6]), 'h99);
    chk("R8 single write", wr_cnt - c0, 1);
    chk("R8 stop releases", int'(sda_oe), 0);
  endtask

  task automatic t_enable();
    logic a;
    i2c_write(8'h08, 8'h01, 1, 8'h00, a);
    chk("R9 enabled", int'(cp_en), 1);
    chk("R9 defaults pulse", ldef_cnt, 1);
    i2c_write(8'h08, 8'h00, 1, 8'h00, a);
    chk("R9 sticky", int'(cp_en), 1);
    i2c_write(8'h08, 8'h01, 1, 8'h00, a);
    chk("R9 no second pulse", ldef_cnt, 1);
  endtask

  task automatic t_spi();
    int c0;
    spi_frame(8'h30, 8'h02, 8'hC3, 8'h00, 1);
    chk("R10 latched", int'(spi_mode), 1);
    chk("R11 write", int'(regs[2]), 'hC3);
    spi_frame(8'h30, 8'h88, 8'h10, 8'h20, 2);
    chk("R11 step at 08", int'(regs[8]), 'h10);
    chk("R11 wrap R4", int'(regs[1]), 'h20);
    c0 = wr_cnt;
    spi_frame(8'h32, 8'h02, 8'h00, 8'h00, 1);
    chk("R11 wrong address ignored", int'(regs[2]), 'hC3);
    chk("R11 no write", wr_cnt - c0, 0);
    chk("R11 never drives", oe_spi_cnt, 0);
    sel = 1'b0; w(Q); sel = 1'b1; w(Q);
    chk("R10 stays latched", int'(spi_mode), 1);
  endtask

  initial begin
    w(5); rst_n = 1'b1; w(5);
    t_reset();
    t_sel_before_enable();
    t_address();
    t_write();
    t_fixed();
    t_bank_lo();
    t_bank_hi();
    t_out_of_range();
    t_read();
    t_restart();
    t_enable();
    t_spi();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule